// File: doc/BRIEF.md
# Step/Direction Microstep Translator

This block turns a stream of step pulses into the winding current pattern of a two-phase bipolar stepper. It keeps an electrical angle as an index into eight positions, 45° apart. Each rising edge on the step input moves the index by one position in half-step mode. In full-step mode it moves to the next diagonal position, where both phases carry current. The direction input sets which way the index moves. For each phase the block outputs a current level, as a magnitude code and a polarity bit. An external DAC and bridge stage turn that level into winding current.

With each step the block also picks a decay mode for each phase. A phase whose current magnitude drops gets mixed decay. A phase whose magnitude rises or stays the same gets slow decay. This lets the external chopper follow falling currents quickly and keep ripple low on rising ones. The step, direction and resolution inputs are asynchronous. Each passes through a two-flop synchroniser before the rising-edge detector, so direction and resolution are taken in the same cycle that the step edge is seen.

Top module: `step_xlat`

## Requirements
- R1: Index p maps to phase A level at angle p·45° and phase B level at angle (p−2)·45°. The sequence for p = 0..7 is A: +100, +70.71, 0, −70.71, −100, −70.71, 0, +70.71 percent, with B trailing A by two positions. Magnitude code is 0 for 0%, 1 for 70.71% and 2 for 100%. The polarity bit is 1 for negative current and 0 for positive or zero current.
- R2: While rst_ni is low, the index is 1 (both phases +70.71%) and both decay flags are 1 (mixed). drv_en_o is 0 during reset and becomes 1 at the first clock edge after release, then stays 1.
- R3: With half_i low (full step), a step from an odd (diagonal) index moves two positions. A step from an even (axis) index moves one position, to the adjacent diagonal in the commanded direction.
- R4: With half_i high (half step), each step moves the index one position.
- R5: dir_i high increments the index and dir_i low decrements it, both modulo 8.
- R6: Only a low-to-high transition of step_i advances the index. Holding step_i high or low causes no movement. A step_i rise first sampled at clock edge n changes the outputs at edge n+2.
- R7: dir_i and half_i are synchronised with the same depth as step_i and are used as sampled at the edge where step_i's rise is sampled. Changing them without a step edge changes no output.
- R8: On each step, a phase whose new magnitude code is lower than its old one gets decay flag 1 (mixed). Otherwise it gets 0 (slow). Between steps the flags hold.
- R9: Step pulses applied while rst_ni is low are ignored: after release the index is still 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, returns to home |
| step_i | input | 1 | Step strobe, rising edge advances (asynchronous) |
| dir_i | input | 1 | Direction, 1 increments index (asynchronous) |
| half_i | input | 1 | Resolution, 1 half step, 0 full step (asynchronous) |
| drv_en_o | output | 1 | Output-stage enable indication |
| pos_o | output | 3 | Electrical angle index |
| a_mag_o | output | 2 | Phase A magnitude code |
| a_neg_o | output | 1 | Phase A polarity, 1 negative |
| a_mixed_o | output | 1 | Phase A decay, 1 mixed, 0 slow |
| b_mag_o | output | 2 | Phase B magnitude code |
| b_neg_o | output | 1 | Phase B polarity, 1 negative |
| b_mixed_o | output | 1 | Phase B decay, 1 mixed, 0 slow |

## Verification
The assertions assume that reset is asserted before the first clock edge. They also assume that any step_i level lasts at least one clock period, so the synchroniser samples it. The step-size properties assume that dir_i and half_i reach the edge detector no later than the step edge they qualify. Equal synchroniser depth guarantees this only when those inputs are stable from the step's sampling edge onward. The directed stimulus changes dir_i and half_i at least a cycle before or together with the step rise and holds each step level for two or more clocks. The random phase changes all inputs freely, and the cycle-accurate model follows the synchronised values exactly.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int POS_W    = 3;
  localparam int NPOS     = 1 << POS_W;
  localparam int MAG_W    = 2;
  localparam int HOME_POS = 1;

  typedef struct packed {
    logic [MAG_W-1:0] mag;
    logic             neg;
  } lvl_t;

  // Cosine of p*45deg; phase B lags by 90deg (two positions).
  function automatic lvl_t phase_lvl(input logic [POS_W-1:0] pos, input logic ph_b);
    logic [POS_W-1:0] p;
    lvl_t l;
    p = ph_b ? pos - POS_W'(2) : pos;
    case (p)
      3'd0:        begin l.mag = 2'd2; l.neg = 1'b0; end
      3'd1, 3'd7:  begin l.mag = 2'd1; l.neg = 1'b0; end
      3'd2, 3'd6:  begin l.mag = 2'd0; l.neg = 1'b0; end
      3'd3, 3'd5:  begin l.mag = 2'd1; l.neg = 1'b1; end
      default:     begin l.mag = 2'd2; l.neg = 1'b1; end
    endcase
    return l;
  endfunction
endpackage

// File: rtl/stx_sync.sv
module stx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/stx_index.sv
module stx_index import stx_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             dir_i,
  input  logic             half_i,
  output logic             adv_o,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] nxt_pos_o
);
  logic             step_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] stride;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= 1'b0;
    else         step_q <= step_i;
  end

  assign adv_o = step_i & ~step_q;

  // full step from a diagonal skips the axis; from an axis lands on the next diagonal
  always_comb begin
    stride    = (!half_i && pos_q[0]) ? POS_W'(2) : POS_W'(1);
    nxt_pos_o = dir_i ? pos_q + stride : pos_q - stride;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pos_q <= POS_W'(HOME_POS);
    else if (adv_o) pos_q <= nxt_pos_o;
  end

  assign pos_o = pos_q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_o |=> $stable(pos_q)); // R6
  AST_HALF_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && half_i) |=> (POS_W'(pos_q - $past(pos_q)) == POS_W'(1) ||
                           POS_W'(pos_q - $past(pos_q)) == POS_W'(NPOS-1))); // R4
  AST_FULL_DIAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && !half_i) |=> pos_q[0]); // R3
  AST_DIR_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && dir_i) |=> (POS_W'(pos_q - $past(pos_q)) == POS_W'(1) ||
                          POS_W'(pos_q - $past(pos_q)) == POS_W'(2))); // R5
  AST_DIR_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && !dir_i) |=> (POS_W'($past(pos_q) - pos_q) == POS_W'(1) ||
                           POS_W'($past(pos_q) - pos_q) == POS_W'(2))); // R5
endmodule

// File: rtl/stx_decay.sv
module stx_decay import stx_pkg::*; #(
  parameter int PHASE = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [POS_W-1:0] cur_pos_i,
  input  logic [POS_W-1:0] nxt_pos_i,
  output lvl_t             lvl_o,
  output logic             mixed_o
);
  localparam logic PH_B = (PHASE != 0);

  lvl_t nxt_lvl;
  logic mixed_q;

  assign lvl_o   = phase_lvl(cur_pos_i, PH_B);
  assign nxt_lvl = phase_lvl(nxt_pos_i, PH_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mixed_q <= 1'b1;
    else if (adv_i) mixed_q <= (nxt_lvl.mag < lvl_o.mag);
  end

  assign mixed_o = mixed_q;

  AST_DECAY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(mixed_q)); // R8
  AST_FALL_MIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_o.mag < $past(lvl_o.mag)) |-> mixed_q); // R8
  AST_RISE_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_o.mag > $past(lvl_o.mag)) |-> !mixed_q); // R8
  AST_ZERO_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_o.mag == '0) |-> !lvl_o.neg); // R1
endmodule

// File: rtl/step_xlat.sv
module step_xlat import stx_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             dir_i,
  input  logic             half_i,
  output logic             drv_en_o,
  output logic [POS_W-1:0] pos_o,
  output logic [MAG_W-1:0] a_mag_o,
  output logic             a_neg_o,
  output logic             a_mixed_o,
  output logic [MAG_W-1:0] b_mag_o,
  output logic             b_neg_o,
  output logic             b_mixed_o
);
  localparam int NPH = 2;

  logic [2:0]       raw_in, syn_in;
  logic             adv;
  logic [POS_W-1:0] cur_pos, nxt_pos;
  lvl_t             lvl   [NPH];
  logic [NPH-1:0]   mixed;
  logic             en_q;

  assign raw_in = {half_i, dir_i, step_i};

  stx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  stx_index u_index (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (syn_in[0]),
    .dir_i    (syn_in[1]),
    .half_i   (syn_in[2]),
    .adv_o    (adv),
    .pos_o    (cur_pos),
    .nxt_pos_o(nxt_pos)
  );

  for (genvar ph = 0; ph < NPH; ph++) begin : g_phase
    stx_decay #(.PHASE(ph)) u_decay (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .adv_i    (adv),
      .cur_pos_i(cur_pos),
      .nxt_pos_i(nxt_pos),
      .lvl_o    (lvl[ph]),
      .mixed_o  (mixed[ph])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= 1'b1;
  end

  assign drv_en_o  = en_q;
  assign pos_o     = cur_pos;
  assign a_mag_o   = lvl[0].mag;
  assign a_neg_o   = lvl[0].neg;
  assign a_mixed_o = mixed[0];
  assign b_mag_o   = lvl[1].mag;
  assign b_neg_o   = lvl[1].neg;
  assign b_mixed_o = mixed[1];

  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_o |=> drv_en_o); // R2
  AST_POS_MOVES_WITH_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(pos_o) |-> ($stable(a_mag_o) && $stable(b_mag_o) && $stable(a_neg_o))); // R1
endmodule

// File: tb/step_xlat_bench.sv
module step_xlat_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic step_i = 1'b0, dir_i = 1'b0, half_i = 1'b0;
  logic drv_en_o, a_neg_o, a_mixed_o, b_neg_o, b_mixed_o;
  logic [2:0] pos_o;
  logic [1:0] a_mag_o, b_mag_o;

  int checks = 0, fails = 0;
  string cur_tag = "R2";
  bit done = 1'b0;

  // reference model state
  int m_pos = 1;
  bit m_mixa = 1'b1, m_mixb = 1'b1, m_en = 1'b0;
  bit [2:0] sh_step = '0, sh_dir = '0, sh_half = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  step_xlat u_step_xlat (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step_i), .dir_i(dir_i), .half_i(half_i),
    .drv_en_o(drv_en_o), .pos_o(pos_o),
    .a_mag_o(a_mag_o), .a_neg_o(a_neg_o), .a_mixed_o(a_mixed_o),
    .b_mag_o(b_mag_o), .b_neg_o(b_neg_o), .b_mixed_o(b_mixed_o)
  );

  function automatic int pct(input int pos, input int ph);
    case ((pos - 2*ph + 16) % 8)
      0: return 100;
      1, 7: return 71;
      2, 6: return 0;
      3, 5: return -71;
      default: return -100;
    endcase
  endfunction

  function automatic int absv(input int v);
    return v < 0 ? -v : v;
  endfunction

  function automatic int mag_code(input int p);
    return absv(p) == 100 ? 2 : (absv(p) == 71 ? 1 : 0);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 1; m_mixa = 1'b1; m_mixb = 1'b1; m_en = 1'b0;
      sh_step = '0; sh_dir = '0; sh_half = '0;
    end else begin
      if (sh_step[1] && !sh_step[2]) begin
        int d, np;
        d  = sh_half[1] ? 1 : ((m_pos % 2 == 0) ? 1 : 2);
        np = sh_dir[1] ? (m_pos + d) % 8 : (m_pos + 8 - d) % 8;
        m_mixa = absv(pct(np, 0)) < absv(pct(m_pos, 0));
        m_mixb = absv(pct(np, 1)) < absv(pct(m_pos, 1));
        m_pos  = np;
      end
      sh_step = {sh_step[1:0], step_i};
      sh_dir  = {sh_dir[1:0], dir_i};
      sh_half = {sh_half[1:0], half_i};
      m_en = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(pos_o == 3'(m_pos), cur_tag, "pos", int'(pos_o), m_pos);
      chk(a_mag_o == 2'(mag_code(pct(m_pos, 0))), "R1", "a_mag", int'(a_mag_o), mag_code(pct(m_pos, 0)));
      chk(a_neg_o == (pct(m_pos, 0) < 0), "R1", "a_neg", int'(a_neg_o), int'(pct(m_pos, 0) < 0));
      chk(b_mag_o == 2'(mag_code(pct(m_pos, 1))), "R1", "b_mag", int'(b_mag_o), mag_code(pct(m_pos, 1)));
      chk(b_neg_o == (pct(m_pos, 1) < 0), "R1", "b_neg", int'(b_neg_o), int'(pct(m_pos, 1) < 0));
      chk(a_mixed_o == m_mixa, "R8", "a_mixed", int'(a_mixed_o), int'(m_mixa));
      chk(b_mixed_o == m_mixb, "R8", "b_mixed", int'(b_mixed_o), int'(m_mixb));
      chk(drv_en_o == m_en, "R2", "drv_en", int'(drv_en_o), int'(m_en));
    end
  end

  task automatic pulse();
    @(posedge clk); #1 step_i = 1'b1;
    repeat (2) @(posedge clk);
    #1 step_i = 1'b0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    // R9: steps during reset are ignored
    cur_tag = "R9";
    half_i = 1'b1; dir_i = 1'b1;
    for (int i = 0; i < 4; i++) pulse();
    chk(pos_o == 3'd1, "R9", "pos in reset", int'(pos_o), 1);
    chk(drv_en_o == 1'b0, "R2", "en in reset", int'(drv_en_o), 0);
    chk(a_mixed_o && b_mixed_o, "R2", "mixed in reset", int'({a_mixed_o, b_mixed_o}), 3);
    chk(a_mag_o == 2'd1 && b_mag_o == 2'd1, "R2", "home mags", int'({a_mag_o, b_mag_o}), 5);
    @(posedge clk); #1 rst_n = 1'b1;
    settle(1);
    chk(drv_en_o == 1'b1, "R2", "en after release", int'(drv_en_o), 1);
    chk(pos_o == 3'd1, "R9", "pos after release", int'(pos_o), 1);

    // R6 latency: rise sampled at edge n, outputs at n+2
    cur_tag = "R6";
    @(posedge clk); #1 step_i = 1'b1;
    @(posedge clk); #2;              // edge n
    chk(pos_o == 3'd1, "R6", "pos at n", int'(pos_o), 1);
    @(posedge clk); #2;              // n+1
    chk(pos_o == 3'd1, "R6", "pos at n+1", int'(pos_o), 1);
    @(posedge clk); #2;              // n+2
    chk(pos_o == 3'd2, "R6", "pos at n+2", int'(pos_o), 2);
    // R4/R8: 1 -> 2: A falls to 0 (mixed), B rises to 100 (slow)
    chk(a_mag_o == 2'd0 && b_mag_o == 2'd2, "R4", "mags at 2", int'({a_mag_o, b_mag_o}), 2);
    chk(a_mixed_o == 1'b1 && b_mixed_o == 1'b0, "R8", "decay at 2", int'({a_mixed_o, b_mixed_o}), 2);
    // R6: held high gives no more movement
    settle(10);
    chk(pos_o == 3'd2, "R6", "held high", int'(pos_o), 2);
    #1 step_i = 1'b0;
    settle(4);

    // R7: dir/half toggles without step do nothing
    cur_tag = "R7";
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1 dir_i = ~dir_i; half_i = ~half_i;
    end
    dir_i = 1'b1; half_i = 1'b1;
    settle(4);
    chk(pos_o == 3'd2, "R7", "no step no move", int'(pos_o), 2);

    // R4/R8: 2 -> 3: A rises to -70 (slow), B falls to 70 (mixed)
    cur_tag = "R4";
    pulse();
    chk(pos_o == 3'd3 && a_neg_o && a_mag_o == 2'd1, "R4", "pos 3", int'(pos_o), 3);
    chk(a_mixed_o == 1'b0 && b_mixed_o == 1'b1, "R8", "decay at 3", int'({a_mixed_o, b_mixed_o}), 1);

    // R3: full step from diagonal 3 up -> 5
    cur_tag = "R3";
    half_i = 1'b0;
    pulse();
    chk(pos_o == 3'd5, "R3", "diag +2", int'(pos_o), 5);
    half_i = 1'b1;
    pulse();
    chk(pos_o == 3'd6, "R4", "half to axis", int'(pos_o), 6);
    // R3: from axis 6 down in full step -> 5
    half_i = 1'b0; dir_i = 1'b0;
    pulse();
    chk(pos_o == 3'd5, "R3", "axis -1", int'(pos_o), 5);

    // R5: wrap downward and upward
    cur_tag = "R5";
    for (int i = 0; i < 4; i++) pulse();
    chk(pos_o == 3'd5, "R5", "full turn down", int'(pos_o), 5);
    half_i = 1'b1; dir_i = 1'b1;
    for (int i = 0; i < 5; i++) pulse();
    chk(pos_o == 3'd2, "R5", "wrap up", int'(pos_o), 2);

    // R7: dir change together with step rise uses the new value
    cur_tag = "R7";
    @(posedge clk); #1 dir_i = 1'b0; step_i = 1'b1;
    settle(4);
    #1 step_i = 1'b0;
    settle(4);
    chk(pos_o == 3'd1, "R7", "dir with step", int'(pos_o), 1);

    // random phase: model compared every cycle
    cur_tag = "R6";
    begin
      int unsigned lf = 32'h1234_5678;
      for (int i = 0; i < 3000; i++) begin
        @(posedge clk); #1;
        lf = lf * 32'd1103515245 + 32'd12345;
        step_i = lf[16]; dir_i = lf[20]; half_i = lf[25];
        if (i == 1500) rst_n = 1'b0;
        if (i == 1504) rst_n = 1'b1;
      end
    end
    step_i = 1'b0;
    settle(5);

    // R2: asynchronous reset mid-run returns home
    #1 rst_n = 1'b0;
    #2;
    chk(pos_o == 3'd1 && drv_en_o == 1'b0, "R2", "async home", int'(pos_o), 1);
    settle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule